// File: doc/BRIEF.md
# Quad-Rail Undervoltage/Overvoltage Fault Supervisor

This block merges the comparator results from four monitored supply rails into two shared active-low fault outputs. One output reports undervoltage and the other reports overvoltage. Every rail gives two flags: its high divider tap has fallen below threshold, and its low divider tap has risen above threshold. Rails 1 and 2 always monitor positive supplies. A two-bit polarity select sets rails 3 and 4 to positive or negative monitoring. A negative rail exchanges the meaning of its two flags.

After every fault has cleared, the undervoltage output stays asserted for a programmable number of clock cycles. Any new fault during that window restarts the count. A bypass input removes this hold time. A build parameter picks one of two variants, and the variant sets what the mode pin does. In the latch variant, a low mode pin makes overvoltage faults latch, and a high mode pin clears the latch and gives overvoltage the same timed release as undervoltage. In the disable variant, a high mode pin holds both outputs deasserted. A supply lockout flag always asserts undervoltage and holds overvoltage off. Every asynchronous flag and pin passes through a two-flop synchronizer.

Top module: `quad_rail_supervisor`

## Requirements
- R1: Rails 1 and 2 (index 0 and 1) are always positive. A set `hi_below_i` bit is an undervoltage fault, and a set `lo_above_i` bit is an overvoltage fault.
- R2: `pol_sel_i` sets the polarity of rails 3 and 4 (index 2 and 3). 2'b11 makes both positive. 2'b01 and 2'b10 make rail 3 positive and rail 4 negative. 2'b00 makes both negative. On a negative rail, `lo_above_i` is the undervoltage fault and `hi_below_i` is the overvoltage fault.
- R3: Undervoltage faults from all rails are ORed into `uv_no`, and overvoltage faults from all rails are ORed into `ov_no`. Both outputs are active low. An input change reaches the outputs on the third rising edge after it is applied: two synchronizer stages plus one state register.
- R4: After all undervoltage faults clear, `uv_no` stays low for `timeout_i` fault-free cycles. It goes high on the timeout_i-th fault-free edge. A value of 0 behaves like 1.
- R5: A fault that appears during the timeout re-asserts the output. The count restarts from zero once the faults clear again.
- R6: While `bypass_i` is high, an asserted output releases on the first fault-free edge.
- R7: In the latch variant (DISABLE_MODE=0), if `mode_i` is low, an asserted `ov_no` stays low after the faults clear, for as long as `mode_i` stays low.
- R8: In the latch variant, if `mode_i` is high, `ov_no` uses the same timed release as `uv_no`.
- R9: In the disable variant (DISABLE_MODE=1), a high `mode_i` forces both outputs high, whatever the rail flags show, unless lockout is set. Outside of that, overvoltage uses the timed release.
- R10: While `lockout_i` is set, `uv_no` is low and `ov_no` is high. When lockout clears, `uv_no` follows the R4 timed release.
- R11: In the disable variant with `mode_i` high, a lockout asserts `uv_no`. It releases on the first edge after the synchronized lockout clears, with no timeout.
- R12: During reset, `uv_no` is low and `ov_no` is high. The synchronizers are cleared, the overvoltage latch is cleared and the timers are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hi_below_i | input | N_RAILS | Per-rail flag: high tap is below threshold (asynchronous) |
| lo_above_i | input | N_RAILS | Per-rail flag: low tap is above threshold (asynchronous) |
| lockout_i | input | 1 | Supply lockout flag (asynchronous) |
| pol_sel_i | input | 2 | Polarity select for the two upper rails (asynchronous) |
| mode_i | input | 1 | Latch control or global disable, depending on the variant (asynchronous) |
| bypass_i | input | 1 | Static timer bypass |
| timeout_i | input | TMO_W | Release timeout in clock cycles (static configuration) |
| uv_no | output | 1 | Undervoltage fault, active low |
| ov_no | output | 1 | Overvoltage fault, active low |

## Verification
The bench builds two instances side by side, one with DISABLE_MODE=0 and one with DISABLE_MODE=1. Both use four rails and the default 20-bit timeout width, which holds the 625000-cycle count that gives 12.5 ms at 50 MHz. Because the timeout is a runtime input, the bench drives it with 6, so that release, retrigger in the middle of the window and the bypass path all fall within a few dozen cycles. Running both variants from the same stimulus lets a single pass check the latch hold, the latch clear, disable forcing and the lockout-while-disabled release against the same rail patterns.

// File: rtl/qrs_pkg.sv
package qrs_pkg;
  typedef enum logic [1:0] {
    POL_ALL_NEG   = 2'b00,
    POL_SPLIT     = 2'b01,
    POL_SPLIT_ALT = 2'b10,
    POL_ALL_POS   = 2'b11
  } pol_sel_e;
endpackage

// File: rtl/qrs_sync.sv
module qrs_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/qrs_pol_map.sv
module qrs_pol_map
  import qrs_pkg::*;
#(
  parameter int N_RAILS = 4
) (
  input  logic [N_RAILS-1:0] hi_below_i,
  input  logic [N_RAILS-1:0] lo_above_i,
  input  pol_sel_e           pol_i,
  output logic               uv_flt_o,
  output logic               ov_flt_o
);
  logic [N_RAILS-1:0] neg, uv_r, ov_r;

  for (genvar i = 0; i < N_RAILS; i++) begin : g_rail
    if (i == N_RAILS - 2) begin : g_sel_lo
      assign neg[i] = (pol_i == POL_ALL_NEG);
    end else if (i == N_RAILS - 1) begin : g_sel_hi
      assign neg[i] = (pol_i != POL_ALL_POS);
    end else begin : g_fixed
      assign neg[i] = 1'b0;
    end
    assign uv_r[i] = neg[i] ? lo_above_i[i] : hi_below_i[i];
    assign ov_r[i] = neg[i] ? hi_below_i[i] : lo_above_i[i];
  end

  assign uv_flt_o = |uv_r;
  assign ov_flt_o = |ov_r;
endmodule

// File: rtl/qrs_fault_timer.sv
module qrs_fault_timer #(
  parameter int TMO_W   = 20,
  parameter bit RST_ACT = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fault_i,
  input  logic             clr_i,
  input  logic             hold_i,
  input  logic             bypass_i,
  input  logic [TMO_W-1:0] timeout_i,
  output logic             act_o
);
  logic             act_q;
  logic [TMO_W-1:0] cnt_q;
  logic [TMO_W:0]   cnt_inc;
  logic             done;

  assign cnt_inc = {1'b0, cnt_q} + {{TMO_W{1'b0}}, 1'b1};
  assign done    = cnt_inc >= {1'b0, timeout_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= RST_ACT;
      cnt_q <= '0;
    end else if (clr_i) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (fault_i) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (act_q) begin
      if (hold_i) begin
        cnt_q <= '0;
      end else if (bypass_i || done) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_inc[TMO_W-1:0];
      end
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/quad_rail_supervisor.sv
module quad_rail_supervisor
  import qrs_pkg::*;
#(
  parameter int N_RAILS      = 4,
  parameter int TMO_W        = 20,
  parameter bit DISABLE_MODE = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_RAILS-1:0] hi_below_i,
  input  logic [N_RAILS-1:0] lo_above_i,
  input  logic               lockout_i,
  input  logic [1:0]         pol_sel_i,
  input  logic               mode_i,
  input  logic               bypass_i,
  input  logic [TMO_W-1:0]   timeout_i,
  output logic               uv_no,
  output logic               ov_no
);
  localparam int SYNC_W = 2 * N_RAILS + 4;

  logic [SYNC_W-1:0]  sync_d, sync_q;
  logic [N_RAILS-1:0] hb_s, la_s;
  logic               lock_s, mode_s;
  logic [1:0]         pol_s;
  logic               uv_flt, ov_flt;
  logic               dis_act, hold_ov;
  logic               uv_act, ov_act;

  assign sync_d = {hi_below_i, lo_above_i, lockout_i, pol_sel_i, mode_i};

  qrs_sync #(.W(SYNC_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sync_d),
    .q_o   (sync_q)
  );

  assign {hb_s, la_s, lock_s, pol_s, mode_s} = sync_q;

  qrs_pol_map #(.N_RAILS(N_RAILS)) u_map (
    .hi_below_i(hb_s),
    .lo_above_i(la_s),
    .pol_i     (pol_sel_e'(pol_s)),
    .uv_flt_o  (uv_flt),
    .ov_flt_o  (ov_flt)
  );

  if (DISABLE_MODE) begin : g_disable
    assign dis_act = mode_s;
    assign hold_ov = 1'b0;
  end else begin : g_latch
    assign dis_act = 1'b0;
    assign hold_ov = ~mode_s;
  end

  qrs_fault_timer #(.TMO_W(TMO_W), .RST_ACT(1'b1)) u_uv_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fault_i  (uv_flt | lock_s),
    .clr_i    (dis_act & ~lock_s),
    .hold_i   (1'b0),
    .bypass_i (bypass_i),
    .timeout_i(timeout_i),
    .act_o    (uv_act)
  );

  qrs_fault_timer #(.TMO_W(TMO_W), .RST_ACT(1'b0)) u_ov_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fault_i  (ov_flt),
    .clr_i    (lock_s | dis_act),
    .hold_i   (hold_ov),
    .bypass_i (bypass_i),
    .timeout_i(timeout_i),
    .act_o    (ov_act)
  );

  assign uv_no = ~uv_act;
  assign ov_no = ~ov_act;
endmodule

// File: rtl/qrs_checker.sv
module qrs_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic uv_no,
  input logic ov_no,
  input logic lock_s,
  input logic dis_act,
  input logic hold_ov,
  input logic uv_flt,
  input logic bypass_i
);
  p_lock_uv_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_s |=> !uv_no);

  p_lock_ov_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_s |=> ov_no);

  p_uv_or_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uv_flt && !dis_act) |=> !uv_no);

  p_dis_force_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_act && !lock_s) |=> (uv_no && ov_no));

  p_ov_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ov_no && hold_ov && !lock_s && !dis_act) |=> !ov_no);

  p_bypass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bypass_i && !uv_flt && !lock_s) |=> uv_no);
endmodule

bind quad_rail_supervisor qrs_checker u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .uv_no   (uv_no),
  .ov_no   (ov_no),
  .lock_s  (lock_s),
  .dis_act (dis_act),
  .hold_ov (hold_ov),
  .uv_flt  (uv_flt),
  .bypass_i(bypass_i)
);

// File: tb/quad_rail_supervisor_tb_top.sv
`timescale 1ns/1ps
module quad_rail_supervisor_tb_top;
  localparam int TW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    hb = '0, la = '0;
  logic          lock = 1'b0, mode = 1'b0, byp = 1'b0;
  logic [1:0]    pol = 2'b11;
  logic [TW-1:0] tmo = TW'(6);
  logic          uv_l, ov_l, uv_d, ov_d;

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R12";
  bit    run_cmp = 1'b0;

  always #10 clk = ~clk;

  quad_rail_supervisor #(.N_RAILS(4), .TMO_W(TW), .DISABLE_MODE(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hi_below_i(hb), .lo_above_i(la),
    .lockout_i(lock), .pol_sel_i(pol), .mode_i(mode), .bypass_i(byp),
    .timeout_i(tmo), .uv_no(uv_l), .ov_no(ov_l));

  quad_rail_supervisor #(.N_RAILS(4), .TMO_W(TW), .DISABLE_MODE(1'b1)) dut_dis_i (
    .clk_i(clk), .rst_ni(rst_n), .hi_below_i(hb), .lo_above_i(la),
    .lockout_i(lock), .pol_sel_i(pol), .mode_i(mode), .bypass_i(byp),
    .timeout_i(tmo), .uv_no(uv_d), .ov_no(ov_d));

  // reference model: inputs delayed by two edges, then one state update
  logic [11:0] d1, d2;
  bit m_uv[2], m_ov[2];
  int m_uc[2], m_oc[2];

  function automatic logic [1:0] faults(logic [11:0] v);
    logic [3:0] h, l;
    logic [1:0] p;
    logic u, o;
    h = v[11:8]; l = v[7:4]; p = v[2:1];
    u = 1'b0; o = 1'b0;
    for (int i = 0; i < 4; i++) begin
      bit ng;
      ng = (i == 2) ? (p == 2'b00) : (i == 3) ? (p != 2'b11) : 1'b0;
      if (ng) begin u |= l[i]; o |= h[i]; end
      else    begin u |= h[i]; o |= l[i]; end
    end
    return {u, o};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      d1 = '0; d2 = '0;
      for (int v = 0; v < 2; v++) begin
        m_uv[v] = 1'b1; m_ov[v] = 1'b0; m_uc[v] = 0; m_oc[v] = 0;
      end
    end else begin
      logic [1:0] f;
      bit lk, dis, hold;
      int lim;
      f = faults(d2);
      lk = d2[3];
      lim = (int'(tmo) == 0) ? 1 : int'(tmo);
      for (int v = 0; v < 2; v++) begin
        dis  = (v == 1) && d2[0];
        hold = (v == 0) && !d2[0];
        if (dis && !lk) begin m_uv[v] = 0; m_uc[v] = 0; end
        else if (f[1] || lk) begin m_uv[v] = 1; m_uc[v] = 0; end
        else if (m_uv[v]) begin
          if (byp || m_uc[v] + 1 >= lim) begin m_uv[v] = 0; m_uc[v] = 0; end
          else m_uc[v]++;
        end
        if (lk || dis) begin m_ov[v] = 0; m_oc[v] = 0; end
        else if (f[0]) begin m_ov[v] = 1; m_oc[v] = 0; end
        else if (m_ov[v]) begin
          if (hold) m_oc[v] = 0;
          else if (byp || m_oc[v] + 1 >= lim) begin m_ov[v] = 0; m_oc[v] = 0; end
          else m_oc[v]++;
        end
      end
      d2 = d1;
      d1 = {hb, la, lock, pol, mode};
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run_cmp && rst_n) begin
      chk(cur_req, "latch uv_no", uv_l, !m_uv[0]);
      chk(cur_req, "latch ov_no", ov_l, !m_ov[0]);
      chk(cur_req, "disable uv_no", uv_d, !m_uv[1]);
      chk(cur_req, "disable ov_no", ov_d, !m_ov[1]);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_hb(int i, int len);
    hb[i] = 1'b1; step(len); hb[i] = 1'b0;
  endtask

  task automatic pulse_la(int i, int len);
    la[i] = 1'b1; step(len); la[i] = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    // R12: reset state
    chk("R12", "reset latch uv_no", uv_l, 1'b0);
    chk("R12", "reset latch ov_no", ov_l, 1'b1);
    chk("R12", "reset disable uv_no", uv_d, 1'b0);
    chk("R12", "reset disable ov_no", ov_d, 1'b1);
    rst_n = 1'b1;
    run_cmp = 1'b1;
    cur_req = "R4"; step(14);
    // R1: fixed positive rails
    cur_req = "R1";
    pulse_hb(0, 3); step(12);
    pulse_hb(1, 2); step(12);
    mode = 1'b1; step(3);
    pulse_la(0, 3); step(12);
    pulse_la(1, 1); step(12);
    // R7: latch holds ov while mode low
    cur_req = "R7";
    mode = 1'b0; step(3);
    pulse_la(0, 2); step(20);
    // R8: mode high releases latch with timeout
    cur_req = "R8";
    mode = 1'b1; step(14);
    pulse_la(1, 2); step(12);
    // R2: polarity encodings
    cur_req = "R2";
    mode = 1'b0;
    for (int p = 3; p >= 0; p--) begin
      pol = 2'(p); step(4);
      pulse_hb(2, 2); step(10);
      pulse_la(2, 2); step(4); mode = 1'b1; step(10); mode = 1'b0; step(3);
      pulse_hb(3, 2); step(10);
      pulse_la(3, 2); step(4); mode = 1'b1; step(10); mode = 1'b0; step(3);
    end
    pol = 2'b11;
    // R3: multiple simultaneous faults, OR behaviour and latency
    cur_req = "R3";
    mode = 1'b1; step(3);
    hb = 4'b0101; la = 4'b1010; step(4);
    hb = 4'b0001; step(3); hb = '0; step(3); la = '0; step(14);
    // R5: retrigger during timeout
    cur_req = "R5";
    pulse_hb(1, 2); step(6);
    pulse_hb(2, 1); step(4);
    pulse_la(3, 1); step(5);
    pulse_hb(0, 1); step(14);
    // R6: bypass
    cur_req = "R6";
    byp = 1'b1; step(2);
    pulse_hb(0, 2); step(6);
    pulse_la(2, 3); step(6);
    byp = 1'b0; step(4);
    // R9: disable forces outputs high
    cur_req = "R9";
    mode = 1'b1;
    hb = 4'b1111; step(6); la = 4'b0011; step(6); hb = '0; la = '0; step(12);
    mode = 1'b0; step(3);
    pulse_la(0, 2); step(4); mode = 1'b1; step(6); mode = 1'b0; step(10);
    // R10: lockout
    cur_req = "R10";
    mode = 1'b1; step(14);
    la[0] = 1'b1; lock = 1'b1; step(6); la[0] = 1'b0; lock = 1'b0; step(14);
    mode = 1'b0; step(3);
    la[1] = 1'b1; step(5); lock = 1'b1; step(5); lock = 1'b0; step(3); la[1] = 1'b0;
    mode = 1'b1; step(16);
    // R11: lockout while disabled
    cur_req = "R11";
    lock = 1'b1; step(5); lock = 1'b0; step(8);
    hb[0] = 1'b1; lock = 1'b1; step(3); lock = 1'b0; step(3); hb[0] = 1'b0; step(10);
    // R4: larger timeout value
    cur_req = "R4";
    tmo = TW'(25); step(2);
    pulse_hb(1, 2); step(35);
    tmo = TW'(0); step(2);
    pulse_hb(3, 2); step(8);
    run_cmp = 1'b0;
    finish_run();
  end
endmodule